// File: doc/BRIEF.md
# Dual-Format Audio Serial Transmitter

This block turns stereo PCM sample pairs into a single serial data line for a receiver that samples on the rising edge of an external bit clock. The bit clock and the frame clock both come from outside. The block samples them on its own system clock `clk_i`, so all of its state lives in one clock domain. A static format pin picks one of two framings. In MSB-justified framing the first data bit sits right at the frame-clock edge. In I2S framing the first data bit comes one bit slot after that edge, and the frame-clock polarity for the left channel is reversed.

The block counts bit-clock falling edges from one frame start to the next. From that count it picks the word length: 24 bits when a frame has 48 or more bit clocks, and the upper 16 bits of each sample otherwise (the 32-clock frame). A parallel sample pair is captured on a one-cycle valid strobe. It is copied into the transmit registers only at the start of a frame, so both halves of a frame always carry the same sample pair.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first bit-clock falling edge, `sdata_o` is 0.
- R2: With `fmt_i` = 0, the left channel is sent while the frame clock is high and the right channel while it is low. The MSB of each channel is driven in the bit slot that begins with the frame-clock edge. Data is two's complement, MSB first.
- R3: With `fmt_i` = 1, the left channel is sent while the frame clock is low. Each channel's MSB is driven one bit slot after the frame-clock edge. The slot that begins at the edge carries the bit the previous channel would have sent in that slot: its LSB when that channel's word fills its half, otherwise 0.
- R4: A frame with 48 or more bit clocks uses 24-bit words taken as `sample[23:0]`. A frame with fewer uses 16-bit words taken as `sample[23:8]`. The length measured over one frame, from frame start to frame start, applies from the next frame start.
- R5: Every bit slot of a half-frame after the last data bit carries 0.
- R6: The sample pair captured by the most recent valid strobe before a frame start is sent in that frame, left then right. A strobe that comes after a frame start is sent in the following frame and is not lost.
- R7: When a valid strobe lands on the cycles around a frame start, the frame sends either the old pair or the new pair as a whole, never a mix. Strobes later than the capture point always go to the following frame.
- R8: `sdata_o` changes only after a bit-clock falling edge, on the third `clk_i` rising edge after that edge reaches the pin. It holds its value through the whole high phase of the bit clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bit and frame clocks |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 1 | Framing select: 0 MSB-justified, 1 I2S |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External frame clock |
| valid_i | input | 1 | One-cycle strobe that captures `left_i` and `right_i` |
| left_i | input | 24 | Left-channel sample, two's complement |
| right_i | input | 24 | Right-channel sample, two's complement |
| sdata_o | output | 1 | Serial data out |

## Verification
The sample-valid capture and the frame-start copy into the transmit registers can happen in the same `clk_i` cycle. The bench provokes this by sliding the valid strobe one cycle at a time across a window from before to after the frame-clock edge, in both framings. For each position it decodes the whole frame from the serial line and requires the frame to carry exactly the old pair or exactly the new pair. It also requires the following frame to carry the new pair, and once the crossover point is passed, later strobe positions must never again land in the same frame. The bench separately checks every bit slot against an arithmetic model for each framing at 32, 48 and 64 bit clocks per frame.

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
package aud_ser_pkg;
  typedef enum logic {
    FMT_MSB_JUST = 1'b0,
    FMT_I2S      = 1'b1
  } fmt_e;

  // frame-clock level that marks the left channel
  function automatic logic left_level(fmt_e f);
    return (f == FMT_MSB_JUST);
  endfunction
endpackage

// File: rtl/aud_ser_pin_sync.sv
`timescale 1ns/1ps
module aud_ser_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic fall_o,
  output logic lr_o
);
  logic [STAGES-1:0] b_sync, l_sync;
  logic              b_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_sync <= '0;
      l_sync <= '0;
      b_last <= 1'b0;
    end else begin
      b_sync <= {b_sync[STAGES-2:0], bclk_i};
      l_sync <= {l_sync[STAGES-2:0], lrclk_i};
      b_last <= b_sync[STAGES-1];
    end
  end

  assign fall_o = b_last & ~b_sync[STAGES-1];
  assign lr_o   = l_sync[STAGES-1];
endmodule

// File: rtl/aud_ser_frame_track.sv
`timescale 1ns/1ps
module aud_ser_frame_track
  import aud_ser_pkg::*;
#(
  parameter int MAX_BPF      = 256,
  parameter int WIDE_MIN_BPF = 48,
  parameter int CNT_W        = $clog2(MAX_BPF + 1),
  parameter int POS_W        = $clog2(MAX_BPF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fmt_e             fmt_i,
  input  logic             fall_i,
  input  logic             lr_i,
  output logic             frame_start_o,
  output logic             is_left_o,
  output logic [POS_W-1:0] pos_o,
  output logic             wl_now_o,
  output logic             wl_q_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             lr_prev_q;
  logic [POS_W-1:0] pos_q, pos_now;
  logic [CNT_W-1:0] cnt_q;
  logic             wl_q, wl_now;
  logic             half_start;

  assign is_left_o     = (lr_i == left_level(fmt_i));
  assign half_start    = fall_i && (lr_i != lr_prev_q);
  assign frame_start_o = half_start && is_left_o;

  always_comb begin
    if (half_start)       pos_now = '0;
    else if (pos_q == '1) pos_now = pos_q;
    else                  pos_now = pos_q + 1'b1;
  end

  // length measured over the frame that just ended applies from this edge
  assign wl_now = frame_start_o ? (cnt_q >= CNT_W'(WIDE_MIN_BPF)) : wl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_prev_q <= 1'b0;
      pos_q     <= '0;
      cnt_q     <= '0;
      wl_q      <= 1'b0;
    end else if (fall_i) begin
      lr_prev_q <= lr_i;
      pos_q     <= pos_now;
      wl_q      <= wl_now;
      if (frame_start_o)                  cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_W'(MAX_BPF))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pos_o    = pos_now;
  assign wl_now_o = wl_now;
  assign wl_q_o   = wl_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/aud_ser_shifter.sv
`timescale 1ns/1ps
module aud_ser_shifter
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  parameter int POS_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic                fall_i,
  input  logic                frame_start_i,
  input  logic                is_left_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                wl_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o,
  output logic [SAMPLE_W-1:0] act_l_o,
  output logic [SAMPLE_W-1:0] act_r_o
);
  localparam int LEN_W = POS_W + 1;

  logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r, word;
  logic [LEN_W-1:0]    len;
  logic                mj_bit, mj_q;

  // on the frame-start edge the pair being copied is already the one to send
  assign word = is_left_i ? (frame_start_i ? hold_l : act_l) : act_r;
  assign len  = wl_i ? LEN_W'(SAMPLE_W) : LEN_W'(NARROW_W);

  always_comb begin
    mj_bit = 1'b0;
    if ({1'b0, pos_i} < len) begin
      for (int i = 0; i < SAMPLE_W; i++) begin
        if (POS_W'(i) == pos_i) mj_bit = word[SAMPLE_W-1-i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l  <= '0;
      hold_r  <= '0;
      act_l   <= '0;
      act_r   <= '0;
      mj_q    <= 1'b0;
      sdata_o <= 1'b0;
    end else begin
      if (valid_i) begin
        hold_l <= left_i;
        hold_r <= right_i;
      end
      if (frame_start_i) begin
        act_l <= hold_l;
        act_r <= hold_r;
      end
      if (fall_i) begin
        mj_q    <= mj_bit;
        sdata_o <= (fmt_i == FMT_I2S) ? mj_q : mj_bit;
      end
    end
  end

  assign act_l_o = act_l;
  assign act_r_o = act_r;
endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int NARROW_W     = 16,
  parameter int WIDE_MIN_BPF = 48,
  parameter int MAX_BPF      = 256,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fmt_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);
  localparam int CNT_W = $clog2(MAX_BPF + 1);
  localparam int POS_W = $clog2(MAX_BPF);

  fmt_e                fmt;
  logic                fall, lr_s, frame_start, is_left, wl_now, wl_q;
  logic [POS_W-1:0]    pos;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] act_l, act_r;

  assign fmt = fmt_e'(fmt_i);

  aud_ser_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .lrclk_i (lrclk_i),
    .fall_o  (fall),
    .lr_o    (lr_s)
  );

  aud_ser_frame_track #(
    .MAX_BPF      (MAX_BPF),
    .WIDE_MIN_BPF (WIDE_MIN_BPF),
    .CNT_W        (CNT_W),
    .POS_W        (POS_W)
  ) u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fmt_i         (fmt),
    .fall_i        (fall),
    .lr_i          (lr_s),
    .frame_start_o (frame_start),
    .is_left_o     (is_left),
    .pos_o         (pos),
    .wl_now_o      (wl_now),
    .wl_q_o        (wl_q),
    .cnt_o         (cnt)
  );

  aud_ser_shifter #(
    .SAMPLE_W (SAMPLE_W),
    .NARROW_W (NARROW_W),
    .POS_W    (POS_W)
  ) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fmt_i         (fmt),
    .fall_i        (fall),
    .frame_start_i (frame_start),
    .is_left_i     (is_left),
    .pos_i         (pos),
    .wl_i          (wl_now),
    .valid_i       (valid_i),
    .left_i        (left_i),
    .right_i       (right_i),
    .sdata_o       (sdata_o),
    .act_l_o       (act_l),
    .act_r_o       (act_r)
  );
endmodule

// File: rtl/aud_ser_tx_chk.sv
`timescale 1ns/1ps
module aud_ser_tx_chk #(
  parameter int SAMPLE_W     = 24,
  parameter int NARROW_W     = 16,
  parameter int WIDE_MIN_BPF = 48,
  parameter int CNT_W        = 9,
  parameter int POS_W        = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fmt_i,
  input logic                fall,
  input logic                frame_start,
  input logic [POS_W-1:0]    pos,
  input logic                wl_now,
  input logic                wl_q,
  input logic [CNT_W-1:0]    cnt,
  input logic [SAMPLE_W-1:0] act_l,
  input logic [SAMPLE_W-1:0] act_r,
  input logic                sdata_o
);
  a_r8_out_only_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(sdata_o));

  a_r4_len_held_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(wl_q));

  a_r4_len_from_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |=> (wl_q == ($past(cnt) >= CNT_W'(WIDE_MIN_BPF))));

  a_r6_pair_only_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> ($stable(act_l) && $stable(act_r)));

  a_r5_fill_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !fmt_i && (int'(pos) >= (wl_now ? SAMPLE_W : NARROW_W))) |=> !sdata_o);
endmodule

bind aud_ser_tx aud_ser_tx_chk #(
  .SAMPLE_W     (SAMPLE_W),
  .NARROW_W     (NARROW_W),
  .WIDE_MIN_BPF (WIDE_MIN_BPF),
  .CNT_W        (CNT_W),
  .POS_W        (POS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fmt_i       (fmt_i),
  .fall        (fall),
  .frame_start (frame_start),
  .pos         (pos),
  .wl_now      (wl_now),
  .wl_q        (wl_q),
  .cnt         (cnt),
  .act_l       (act_l),
  .act_r       (act_r),
  .sdata_o     (sdata_o)
);

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
module sim_aud_ser_tx;
  localparam int BH = 8;

  logic        clk = 1'b0, rst_n = 1'b0, fmt = 1'b0;
  logic        bclk = 1'b1, lrclk = 1'b1, valid = 1'b0;
  logic [23:0] l_in = '0, r_in = '0;
  logic        sdata;

  always #2.5 clk = ~clk;

  aud_ser_tx u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .fmt_i   (fmt),
    .bclk_i  (bclk),
    .lrclk_i (lrclk),
    .valid_i (valid),
    .left_i  (l_in),
    .right_i (r_in),
    .sdata_o (sdata)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;
  int s0_cyc = -1000, s1_cyc = -1000;
  logic [23:0] s0_l, s0_r, s1_l, s1_r;
  bit rec [0:255];

  always @(negedge clk) begin
    valid = 1'b0;
    if (cyc == s0_cyc) begin valid = 1'b1; l_in = s0_l; r_in = s0_r; end
    if (cyc == s1_cyc) begin valid = 1'b1; l_in = s1_l; r_in = s1_r; end
  end

  function automatic logic mjb(logic [23:0] w, int q, int wl);
    return (q >= 0 && q < wl) ? w[23-q] : 1'b0;
  endfunction

  function automatic logic [23:0] pat(int n);
    case (n % 5)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'h000001;
      default: return 24'(n * 32'h009E3779) ^ 24'h5A5A5A;
    endcase
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(int bpf, bit en, logic [23:0] el, logic [23:0] er, logic [23:0] pr);
    int half;
    int wl;
    logic lvl;
    half = bpf / 2;
    wl = (bpf >= 48) ? 24 : 16;
    lvl = (fmt == 1'b0);
    for (int k = 0; k < bpf; k++) begin
      int p;
      bit rh;
      logic e, got;
      string req;
      p = k % half;
      rh = (k >= half);
      lrclk = rh ? ~lvl : lvl;
      bclk = 1'b0;
      repeat (BH) @(negedge clk);
      got = sdata;
      rec[k] = got;
      if (fmt == 1'b0) e = mjb(rh ? er : el, p, wl);
      else if (p == 0) e = mjb(rh ? el : pr, half - 1, wl);
      else             e = mjb(rh ? er : el, p - 1, wl);
      if (p - int'(fmt) >= wl || (fmt && p == 0 && half > wl)) req = "R5 fill slot";
      else if (bpf == 32) req = fmt ? "R3,R4 narrow i2s bit" : "R2,R4 narrow msb-just bit";
      else                req = fmt ? "R3,R4 wide i2s bit" : "R2,R4 wide msb-just bit";
      if (en) chk(req, 24'(got), 24'(e));
      bclk = 1'b1;
      repeat (BH) @(negedge clk);
      if (en) chk("R8 held through high phase", 24'(sdata), 24'(got));
    end
  endtask

  function automatic logic [23:0] dec(int off);
    logic [23:0] w;
    for (int i = 0; i < 24; i++) w[23-i] = rec[off+i];
    return w;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    logic [23:0] prev_l, prev_r, last_r, el, er;
    int n;
    prev_l = '0; prev_r = '0; last_r = '0; n = 0;
    repeat (6) @(negedge clk);
    chk("R1 low in reset", 24'(sdata), 24'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 low before first fall", 24'(sdata), 24'd0);

    for (int f = 0; f < 2; f++) begin
      fmt = f[0];
      for (int bi = 0; bi < 3; bi++) begin
        int bpf;
        bpf = (bi == 0) ? 32 : (bi == 1) ? 48 : 64;
        for (int fr = 0; fr < 6; fr++) begin
          el = prev_l; er = prev_r;
          s0_l = pat(n); s0_r = pat(n + 1);
          s0_cyc = cyc + bpf * BH;
          run_frame(bpf, fr >= 2, el, er, last_r);
          last_r = er; prev_l = s0_l; prev_r = s0_r; n += 2;
        end
      end
    end

    // strobe swept across the frame-start capture point
    for (int f = 0; f < 2; f++) begin
      bit seen_a;
      fmt = f[0];
      seen_a = 0;
      for (int w = 0; w < 2; w++) begin
        s0_l = pat(n); s0_r = pat(n + 1); n += 2;
        s0_cyc = cyc + 20;
        run_frame(64, 0, '0, '0, '0);
      end
      for (int d = -4; d <= 8; d++) begin
        logic [23:0] al, ar, yl, yr, zl, zr;
        int ex;
        al = pat(n); ar = pat(n + 3); n += 2;
        ex = cyc;
        s0_l = al; s0_r = ar; s0_cyc = ex + 20;
        s1_l = ~al; s1_r = ~ar; s1_cyc = ex + 64 * 2 * BH + d;
        run_frame(64, 0, '0, '0, '0);
        run_frame(64, 0, '0, '0, '0);
        yl = dec(int'(fmt)); yr = dec(32 + int'(fmt));
        run_frame(64, 0, '0, '0, '0);
        zl = dec(int'(fmt)); zr = dec(32 + int'(fmt));
        checks++;
        if (!((yl == al && yr == ar) || (yl == ~al && yr == ~ar))) begin
          fails++;
          $display("FAIL R7 mixed pair d=%0d actual=%h/%h expected=%h/%h or %h/%h",
                   d, yl, yr, al, ar, ~al, ~ar);
        end
        chk("R6 strobe reaches next frame left", zl, ~al);
        chk("R6 strobe reaches next frame right", zr, ~ar);
        if (yl == al) seen_a = 1;
        else if (seen_a) begin
          checks++; fails++;
          $display("FAIL R7 later strobe overtook d=%0d actual=%h expected=%h", d, yl, al);
        end
        if (d == -4) chk("R7 early strobe in this frame", yl, ~al);
        if (d == 8)  chk("R7 late strobe deferred", yl, al);
      end
    end

    done = 1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=running expected=done");
      finish_run();
    end
  end
endmodule